// File: doc/BRIEF.md
# Listen-Window Receive-Mode Detector

This block runs on the recovered RF-period clock of a low-frequency transponder. It watches for the reader's request to switch the tag from broadcasting into command reception. A field-gap detector supplies one pulse per falling edge of the reader field. The frame sequencer supplies two inputs: a strobe at the start of each listen window, and a level that is high while the listen window is in its modulated phase.

The reader asks for receive mode by sending two "0" symbols in a row. The first must land a few RF clocks into the modulated phase of a listen window. The second must follow one symbol period (64 RF clocks, with a tolerance) later. When both are accepted, the block:

- pulses a detect output for one clock;
- holds a command-expected level, which the sequencer uses to gate its modulation off.

It stays in that state until the command handler reports that the command phase is finished. It then waits for a fresh listen-window strobe before it hunts again. A badly timed edge ends the attempt with a noise pulse. A missing second zero ends it with a timeout pulse. Decoding the command bits is left to another block.

Top module: `liw_rxmode_detect`

## Requirements
- R1: After reset, rxModeHit, cmdExpected, errNoise and errTimeout are all low, and the detector waits for a liwStart strobe.
- R2: A first zero is accepted only when edgeIn arrives at an offset of 1 to 7 clocks after the liwStart strobe while modOn is high. Offset k means edgeIn is sampled k clock edges after the edge that sampled the strobe.
- R3: An edgeIn at an offset of 1 to 32 that fails R2 (outside 1..7, or modOn low) gives a one-clock errNoise pulse and drops the partial match. Later edges are then ignored until the next strobe.
- R4: After an accepted first zero, a second edgeIn at a gap of 56 to 72 clocks produces a one-clock rxModeHit pulse, and cmdExpected rises on the same clock.
- R5: A second edgeIn at a gap below 56 clocks gives a one-clock errNoise pulse and no rxModeHit.
- R6: If no second edgeIn has been accepted by a gap of 72 clocks, a one-clock errTimeout pulse is given and the detector waits for the next strobe.
- R7: edgeIn pulses with no strobe before them, or arriving past offset 32 without an accepted first zero, produce no output pulse.
- R8: While cmdExpected is high, edgeIn and liwStart have no effect. A cmdDone pulse clears cmdExpected, and a new detection then needs a new liwStart strobe.
- R9: rxModeHit, errNoise and errTimeout are never high on two consecutive clocks, and errNoise and errTimeout are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF-period clock |
| rstN | input | 1 | Active-low synchronous reset |
| liwStart | input | 1 | One-clock strobe at the start of a listen window |
| modOn | input | 1 | High while the listen window is in its modulated phase |
| edgeIn | input | 1 | One-clock pulse per detected reader field falling edge |
| cmdDone | input | 1 | One-clock pulse when the command phase has ended |
| rxModeHit | output | 1 | One-clock pulse when the two-zero pattern is accepted |
| cmdExpected | output | 1 | High from detection until cmdDone; gates modulation off |
| errNoise | output | 1 | One-clock pulse on a badly timed edge |
| errTimeout | output | 1 | One-clock pulse when the second zero does not arrive |

## Verification
Suppose the state register stays in hunting after a success, or is left stuck in the command state. The fault shows on cmdExpected at the next cmdDone, or as a missing rxModeHit on the next valid pattern, one attempt later. Suppose an offset or gap counter is off by one. The fault shows at the window edges: offsets 7 and 8, gaps 55, 56, 72 and 73. There it turns a hit into errNoise or errTimeout, or the reverse, within one clock of the deciding edge. A stuck pulse register shows as a pulse wider than one clock on the very attempt where it is first set.

// File: rtl/liwdet_pkg.sv
package liwdet_pkg;

  typedef enum logic [1:0] {
    ST_ARMED,
    ST_HUNT1,
    ST_HUNT2,
    ST_CMD
  } detState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ofsLoad;
    logic gapLoad;
  } dpCtl_t;

  // timing comparisons returned by the datapath
  typedef struct packed {
    logic ofsInWin;
    logic ofsEnd;
    logic gapEarly;
    logic gapInWin;
    logic gapLate;
  } dpFlags_t;

endpackage

// File: rtl/liwdet_datapath.sv
module liwdet_datapath
  import liwdet_pkg::*;
#(
  parameter int OFS_MIN  = 1,
  parameter int OFS_MAX  = 7,
  parameter int OFS_SPAN = 32,
  parameter int GAP_NOM  = 64,
  parameter int GAP_TOL  = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  dpCtl_t   ctl,
  output dpFlags_t flags
);

  localparam int GAP_LO = GAP_NOM - GAP_TOL;
  localparam int GAP_HI = GAP_NOM + GAP_TOL;
  localparam int OFS_W  = $clog2(OFS_SPAN + 2);
  localparam int GAP_W  = $clog2(GAP_HI + 2);
  localparam logic [OFS_W-1:0] OFS_TOP = OFS_W'(OFS_SPAN + 1);
  localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(GAP_HI + 1);

  logic [OFS_W-1:0] ofsCnt;
  logic [GAP_W-1:0] gapCnt;

  // clocks elapsed since the listen-window strobe, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ofsCnt <= '0;
    end else if (ctl.ofsLoad) begin
      ofsCnt <= OFS_W'(1);
    end else if (ofsCnt != OFS_TOP) begin
      ofsCnt <= ofsCnt + OFS_W'(1);
    end
  end

  // clocks elapsed since the first accepted zero, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (ctl.gapLoad) begin
      gapCnt <= GAP_W'(1);
    end else if (gapCnt != GAP_TOP) begin
      gapCnt <= gapCnt + GAP_W'(1);
    end
  end

  always_comb begin
    flags.ofsInWin = (ofsCnt >= OFS_W'(OFS_MIN)) && (ofsCnt <= OFS_W'(OFS_MAX));
    flags.ofsEnd   = (ofsCnt >= OFS_W'(OFS_SPAN));
    flags.gapEarly = (gapCnt <  GAP_W'(GAP_LO));
    flags.gapInWin = (gapCnt >= GAP_W'(GAP_LO)) && (gapCnt <= GAP_W'(GAP_HI));
    flags.gapLate  = (gapCnt >= GAP_W'(GAP_HI));
  end

endmodule

// File: rtl/liwdet_ctrl.sv
module liwdet_ctrl
  import liwdet_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     liwStart,
  input  logic     modOn,
  input  logic     edgeIn,
  input  logic     cmdDone,
  input  dpFlags_t flags,
  output dpCtl_t   ctl,
  output logic     rxModeHit,
  output logic     cmdExpected,
  output logic     errNoise,
  output logic     errTimeout
);

  detState_t state, stateNxt;
  logic hitNxt, noiseNxt, timeoutNxt;

  always_comb begin
    stateNxt   = state;
    ctl        = '0;
    hitNxt     = 1'b0;
    noiseNxt   = 1'b0;
    timeoutNxt = 1'b0;
    unique case (state)
      ST_ARMED: begin
        if (liwStart) begin
          ctl.ofsLoad = 1'b1;
          stateNxt    = ST_HUNT1;
        end
      end
      ST_HUNT1: begin
        if (liwStart) begin
          ctl.ofsLoad = 1'b1;
        end else if (edgeIn) begin
          if (modOn && flags.ofsInWin) begin
            ctl.gapLoad = 1'b1;
            stateNxt    = ST_HUNT2;
          end else begin
            noiseNxt = 1'b1;
            stateNxt = ST_ARMED;
          end
        end else if (flags.ofsEnd) begin
          stateNxt = ST_ARMED;
        end
      end
      ST_HUNT2: begin
        if (edgeIn) begin
          if (flags.gapInWin) begin
            hitNxt   = 1'b1;
            stateNxt = ST_CMD;
          end else begin
            noiseNxt = 1'b1;
            stateNxt = ST_ARMED;
          end
        end else if (flags.gapLate) begin
          timeoutNxt = 1'b1;
          stateNxt   = ST_ARMED;
        end
      end
      ST_CMD: begin
        if (cmdDone) begin
          stateNxt = ST_ARMED;
        end
      end
      default: stateNxt = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_ARMED;
      rxModeHit  <= 1'b0;
      errNoise   <= 1'b0;
      errTimeout <= 1'b0;
    end else begin
      state      <= stateNxt;
      rxModeHit  <= hitNxt;
      errNoise   <= noiseNxt;
      errTimeout <= timeoutNxt;
    end
  end

  assign cmdExpected = (state == ST_CMD);

  AST_HIT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    rxModeHit |=> !rxModeHit); // R9
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(errNoise && errTimeout)); // R9
  AST_NOISE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    errNoise |=> !errNoise); // R3
  AST_HIT_WITH_CMD: assert property (@(posedge clk) disable iff (!rstN)
    rxModeHit |-> cmdExpected); // R4
  AST_CMD_ONLY_BY_HIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdExpected) |-> rxModeHit); // R4
  AST_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdExpected && !cmdDone) |=> cmdExpected); // R8
  AST_CMD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdExpected && cmdDone) |=> !cmdExpected); // R8

endmodule

// File: rtl/liw_rxmode_detect.sv
module liw_rxmode_detect
  import liwdet_pkg::*;
#(
  parameter int OFS_MIN  = 1,
  parameter int OFS_MAX  = 7,
  parameter int OFS_SPAN = 32,
  parameter int GAP_NOM  = 64,
  parameter int GAP_TOL  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic liwStart,
  input  logic modOn,
  input  logic edgeIn,
  input  logic cmdDone,
  output logic rxModeHit,
  output logic cmdExpected,
  output logic errNoise,
  output logic errTimeout
);

  dpCtl_t   dpCtl;
  dpFlags_t dpFlags;

  liwdet_datapath #(
    .OFS_MIN (OFS_MIN),
    .OFS_MAX (OFS_MAX),
    .OFS_SPAN(OFS_SPAN),
    .GAP_NOM (GAP_NOM),
    .GAP_TOL (GAP_TOL)
  ) dp_i (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (dpCtl),
    .flags(dpFlags)
  );

  liwdet_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .liwStart   (liwStart),
    .modOn      (modOn),
    .edgeIn     (edgeIn),
    .cmdDone    (cmdDone),
    .flags      (dpFlags),
    .ctl        (dpCtl),
    .rxModeHit  (rxModeHit),
    .cmdExpected(cmdExpected),
    .errNoise   (errNoise),
    .errTimeout (errTimeout)
  );

endmodule

// File: tb/liw_rxmode_detect_tb_top.sv
module liw_rxmode_detect_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic liwStart = 1'b0;
  logic modOn = 1'b0;
  logic edgeIn = 1'b0;
  logic cmdDone = 1'b0;
  logic rxModeHit, cmdExpected, errNoise, errTimeout;

  int checks = 0;
  int errors = 0;
  int hitCyc = 0, noiseCyc = 0, toCyc = 0;
  int consecBad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  liw_rxmode_detect dut_i (
    .clk(clk), .rstN(rstN), .liwStart(liwStart), .modOn(modOn),
    .edgeIn(edgeIn), .cmdDone(cmdDone), .rxModeHit(rxModeHit),
    .cmdExpected(cmdExpected), .errNoise(errNoise), .errTimeout(errTimeout)
  );

  // pulse monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (rxModeHit)  hitCyc++;
    if (errNoise)   noiseCyc++;
    if (errTimeout) toCyc++;
    if ((rxModeHit && errNoise) || (errNoise && errTimeout)) consecBad++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // outcome model: 0 none, 1 hit, 2 noise, 3 timeout; gap<0 means no second edge
  function automatic int expOutcome(int ofs, bit mod, int gap);
    if (ofs > 32) return 0;                            // R7
    if (!(mod && ofs >= 1 && ofs <= 7)) return 2;      // R3
    if (gap < 0 || gap > 72) return 3;                 // R6
    if (gap < 56) return 2;                            // R5
    return 1;                                          // R4
  endfunction

  task automatic clearCounts();
    hitCyc = 0; noiseCyc = 0; toCyc = 0;
  endtask

  // strobe, first edge at offset ofs, optional second edge gap clocks later
  task automatic attempt(input int ofs, input bit mod, input int gap);
    @(negedge clk);
    clearCounts();
    modOn = mod;
    liwStart = 1'b1;
    @(negedge clk);
    liwStart = 1'b0;
    repeat (ofs - 1) @(negedge clk);
    edgeIn = 1'b1;
    @(negedge clk);
    edgeIn = 1'b0;
    if (gap >= 2) begin
      repeat (gap - 1) @(negedge clk);
      edgeIn = 1'b1;
      @(negedge clk);
      edgeIn = 1'b0;
    end
    repeat (100) @(negedge clk);
    modOn = 1'b0;
  endtask

  task automatic judge(input string tag, input int ofs, input bit mod, input int gap);
    int e;
    e = expOutcome(ofs, mod, gap);
    check({tag, " hit cycles"},     hitCyc,   (e == 1) ? 1 : 0);
    check({tag, " noise cycles"},   noiseCyc, (e == 2) ? 1 : 0);
    check({tag, " timeout cycles"}, toCyc,    (e == 3) ? 1 : 0);
    check({tag, " cmdExpected"},    int'(cmdExpected), (e == 1) ? 1 : 0);
  endtask

  task automatic finishCmd();
    @(negedge clk);
    cmdDone = 1'b1;
    @(negedge clk);
    cmdDone = 1'b0;
  endtask

  task automatic run(input string tag, input int ofs, input bit mod, input int gap);
    attempt(ofs, mod, gap);
    judge(tag, ofs, mod, gap);
    if (cmdExpected) finishCmd();
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rxModeHit", int'(rxModeHit), 0);
    check("R1 cmdExpected", int'(cmdExpected), 0);
    check("R1 errNoise", int'(errNoise), 0);
    check("R1 errTimeout", int'(errTimeout), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R7 edges without a strobe are ignored
    clearCounts();
    modOn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      edgeIn = 1'b1; @(negedge clk); edgeIn = 1'b0;
      repeat (63) @(negedge clk);
    end
    modOn = 1'b0;
    repeat (80) @(negedge clk);
    check("R7 no-strobe pulses", hitCyc + noiseCyc + toCyc, 0);

    // directed corners
    run("R2 R4 ofs1 gap56", 1, 1'b1, 56);
    run("R2 R4 ofs7 gap72", 7, 1'b1, 72);
    run("R2 R4 ofs4 gap64", 4, 1'b1, 64);
    run("R3 ofs8", 8, 1'b1, 64);
    run("R3 ofs32", 32, 1'b1, 64);
    run("R3 modOn low", 3, 1'b0, 64);
    run("R5 gap55", 3, 1'b1, 55);
    run("R6 gap73", 3, 1'b1, 73);
    run("R6 no second", 3, 1'b1, -1);
    run("R7 ofs33", 33, 1'b1, 64);

    // R8: command phase ignores strobes and edges
    attempt(2, 1'b1, 60);
    judge("R8 setup", 2, 1'b1, 60);
    attempt(2, 1'b1, 60);
    check("R8 hit during cmd", hitCyc, 0);
    check("R8 noise during cmd", noiseCyc + toCyc, 0);
    check("R8 cmd held", int'(cmdExpected), 1);
    finishCmd();
    @(negedge clk);
    check("R8 cleared by cmdDone", int'(cmdExpected), 0);
    // re-arm only via strobe: edges alone stay silent
    clearCounts();
    modOn = 1'b1;
    edgeIn = 1'b1; @(negedge clk); edgeIn = 1'b0;
    repeat (59) @(negedge clk);
    edgeIn = 1'b1; @(negedge clk); edgeIn = 1'b0;
    modOn = 1'b0;
    repeat (90) @(negedge clk);
    check("R8 no rearm without strobe", hitCyc + noiseCyc + toCyc + int'(cmdExpected), 0);
    run("R8 rearm after strobe", 5, 1'b1, 66);

    // constrained random
    for (int n = 0; n < 60; n++) begin
      int ofs, gap;
      bit mod;
      ofs = 1 + int'($urandom_range(39));
      mod = ($urandom_range(3) != 0);
      if ($urandom_range(7) == 0) gap = -1;
      else if ($urandom_range(1) == 0) gap = 50 + int'($urandom_range(28));
      else gap = 40 + int'($urandom_range(50));
      run($sformatf("R2 R3 R4 R5 R6 rnd%0d", n), ofs, mod, gap);
    end

    check("R9 simultaneous pulses", consecBad, 0);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule